// File: doc/BRIEF.md
# Low-Power Mode and Clock Controller

This block holds the system-control byte of a small low-power microcontroller. When the CPU issues a sleep request, the block chooses the low-power state to enter. It also picks the clock that feeds the CPU. The control byte has four fields: a standby enable, a stabilisation-time code, a low-speed flag and a medium-speed divider code. Two more inputs take part in the choice. One reports whether the subclock timer is running, and the other asks for medium-speed operation.

A wake-up interrupt brings the CPU back. From light sleep the return is immediate. From states where the main oscillator was stopped, the block first counts a stabilisation wait on the oscillator clock and holds the CPU until the count ends. A build parameter picks one of two tables of wait lengths. The block also produces a one-cycle tick at the selected medium-speed rate. Gating the clocks and running the oscillators are left to neighbouring logic.

Top module: `pwr_mode_ctl`

## Requirements
- R1: The control byte resets to 0x07. Its fields are bit 7 standby enable, bits 6:4 wait code, bit 3 low-speed flag and bits 1:0 divider code. Bit 2 always reads 1 and ignores writes. A write takes effect on the clock edge that samples `reg_we`.
- R2: With bit 7 at 0, a sleep request moves the block to sleep (mode 2) when the low-speed flag is 0 and to subsleep (mode 3) when it is 1. While the CPU is running, `mode` reports 0 for active and 1 for subactive, following the low-speed flag.
- R3: With bit 7 at 1, a sleep request from subactive enters watch (mode 5). From active it enters watch when `subtmr_en` is 1 and standby (mode 4) when `subtmr_en` is 0.
- R4: A wake-up from sleep or subsleep, or from watch with the low-speed flag at 1, returns the block to running mode on the next clock with no wait.
- R5: A wake-up from standby, or from watch with the low-speed flag at 0, enters the stabilising state (mode 6) with `cpu_run` low. `cpu_run` rises exactly N clock edges after the edge that samples `wake_irq`. With `ALT_WAIT`=0, codes 0 to 7 give N = 8192, 16384, 1024, 2048, 4096, 2, 8 and 16.
- R6: With `ALT_WAIT`=1, codes 2, 3 and 4 give N = 32768, 65536 and 131072. The other codes keep their default values.
- R7: A register write during the stabilising wait updates the byte but leaves the wait already in progress unchanged.
- R8: `sleep_req` has no effect unless the CPU is running. `wake_irq` has no effect while the CPU is running or stabilising.
- R9: `clk_src` is 2'b10 (subclock) when the low-speed flag is 1. Otherwise it is 2'b01 (divided clock) when `med_req` is 1, and 2'b00 (full system clock) when it is 0.
- R10: `med_tick` pulses for one cycle every 16, 32, 64 or 128 clock cycles, for divider codes 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read data |
| sleep_req | input | 1 | Sleep request strobe from the CPU |
| wake_irq | input | 1 | Wake-up interrupt |
| subtmr_en | input | 1 | Subclock timer is running |
| med_req | input | 1 | Request for medium-speed operation |
| mode | output | 3 | Current power state code |
| cpu_run | output | 1 | CPU may execute |
| clk_src | output | 2 | CPU clock source selection |
| med_tick | output | 1 | Medium-speed clock enable pulse |

## Verification
Every state change is registered once, so `mode` and `cpu_run` change after the edge that samples a sleep or wake strobe. The bench drives each strobe for one cycle from a falling edge and reads the result at the following falling edge. For a stabilising wake it reads `cpu_run` again after N-1 further edges, where it must still be low, and after N edges, where it must be high. The expected N comes from the bench's own table. Register reads and `clk_src` follow a write by one edge. `med_tick` spacing is measured between two consecutive pulses, so the phase of the divider counter does not affect the result.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter bit ALT_WAIT = 1'b0,
  parameter int CNT_W    = 17,
  parameter int DIV_W    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sleep_req,
  input  logic       wake_irq,
  input  logic       subtmr_en,
  input  logic       med_req,
  output logic [2:0] mode,
  output logic       cpu_run,
  output logic [1:0] clk_src,
  output logic       med_tick
);
  localparam logic [2:0] ST_RUN      = 3'd0;
  localparam logic [2:0] ST_SLEEP    = 3'd2;
  localparam logic [2:0] ST_SUBSLEEP = 3'd3;
  localparam logic [2:0] ST_STANDBY  = 3'd4;
  localparam logic [2:0] ST_WATCH    = 3'd5;
  localparam logic [2:0] ST_STAB     = 3'd6;
  localparam logic [7:0] CTL_RST     = 8'h07;

  logic [7:0]       ctl_q;
  logic [2:0]       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_mask;
  logic [2:0]       sleep_dst;
  logic [CNT_W-1:0] wait_load;

  wire       sby  = ctl_q[7];
  wire [2:0] wsel = ctl_q[6:4];
  wire       lson = ctl_q[3];
  wire [1:0] msel = ctl_q[1:0];

  function automatic int wait_len(input logic [2:0] code);
    case (code)
      3'd0:    return 8192;
      3'd1:    return 16384;
      3'd2:    return ALT_WAIT ? 32768 : 1024;
      3'd3:    return ALT_WAIT ? 65536 : 2048;
      3'd4:    return ALT_WAIT ? 131072 : 4096;
      3'd5:    return 2;
      3'd6:    return 8;
      default: return 16;
    endcase
  endfunction

  assign wait_load = CNT_W'(wait_len(wsel) - 1);
  assign sleep_dst = !sby ? (lson ? ST_SUBSLEEP : ST_SLEEP)
                          : ((lson || subtmr_en) ? ST_WATCH : ST_STANDBY);

  assign reg_rdata = ctl_q;
  assign cpu_run   = (st_q == ST_RUN);
  assign mode      = cpu_run ? {2'b00, lson} : st_q;
  assign clk_src   = lson ? 2'b10 : (med_req ? 2'b01 : 2'b00);
  assign div_mask  = DIV_W'((32'd16 << msel) - 32'd1);
  assign med_tick  = &(div_q | ~div_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      st_q  <= ST_RUN;
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (reg_we) ctl_q <= {reg_wdata[7:3], 1'b1, reg_wdata[1:0]};
      case (st_q)
        ST_RUN: if (sleep_req) st_q <= sleep_dst;
        ST_SLEEP, ST_SUBSLEEP: if (wake_irq) st_q <= ST_RUN;
        ST_WATCH:
          if (wake_irq) begin
            if (lson) st_q <= ST_RUN;
            else begin
              st_q  <= ST_STAB;
              cnt_q <= wait_load;
            end
          end
        ST_STANDBY:
          if (wake_irq) begin
            st_q  <= ST_STAB;
            cnt_q <= wait_load;
          end
        ST_STAB:
          if (cnt_q == '0) st_q <= ST_RUN;
          else cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

module pwr_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       sleep_req,
  input logic       wake_irq,
  input logic [2:0] mode,
  input logic       cpu_run,
  input logic       med_tick
);
  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && mode == 3'd0 && !reg_rdata[7]) |=> (mode == 3'd2));
  // R3
  watch_from_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && mode == 3'd1 && reg_rdata[7]) |=> (mode == 3'd5));
  // R4
  wake_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && (mode == 3'd2 || mode == 3'd3)) |=> cpu_run);
  // R5
  stab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6) |=> (mode == 3'd6 || mode == 3'd0));
  // R8
  run_ignore_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && !sleep_req) |=> cpu_run);
  // R10
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    med_tick |=> !med_tick);
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
  .wake_irq(wake_irq), .mode(mode), .cpu_run(cpu_run), .med_tick(med_tick)
);

// File: tb/pwr_mode_ctl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, sleep_req = 1'b0, wake_irq = 1'b0, subtmr_en = 1'b0, med_req = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] mode;
  logic cpu_run, med_tick;
  logic [1:0] clk_src;

  logic a_we = 1'b0, a_slp = 1'b0, a_wk = 1'b0;
  logic [7:0] a_wd = '0;
  logic [7:0] a_rd;
  logic [2:0] a_mode;
  logic a_run, a_tick;
  logic [1:0] a_src;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_mode_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sleep_req(sleep_req), .wake_irq(wake_irq), .subtmr_en(subtmr_en), .med_req(med_req),
    .mode(mode), .cpu_run(cpu_run), .clk_src(clk_src), .med_tick(med_tick));

  pwr_mode_ctl #(.ALT_WAIT(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .reg_we(a_we), .reg_wdata(a_wd), .reg_rdata(a_rd),
    .sleep_req(a_slp), .wake_irq(a_wk), .subtmr_en(1'b0), .med_req(1'b0),
    .mode(a_mode), .cpu_run(a_run), .clk_src(a_src), .med_tick(a_tick));

  // {ctl byte, subtmr_en, mode after sleep, mode after run resumes, wait N (0 = none)}
  localparam logic [31:0] VEC [0:8] = '{
    {8'h00, 1'b0, 3'd2, 3'd0, 17'd0},
    {8'h08, 1'b0, 3'd3, 3'd1, 17'd0},
    {8'hD0, 1'b0, 3'd4, 3'd0, 17'd2},
    {8'hE0, 1'b1, 3'd5, 3'd0, 17'd8},
    {8'hF8, 1'b0, 3'd5, 3'd1, 17'd0},
    {8'hF0, 1'b0, 3'd4, 3'd0, 17'd16},
    {8'hA0, 1'b0, 3'd4, 3'd0, 17'd1024},
    {8'h80, 1'b0, 3'd4, 3'd0, 17'd8192},
    {8'h90, 1'b0, 3'd4, 3'd0, 17'd16384}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_irq = 1'b1;
    @(negedge clk);
    wake_irq = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, per;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", reg_rdata, 8'h07);
    chk("R2 reset mode", mode, 3'd0);
    chk("R8 reset run", cpu_run, 1'b1);
    chk("R9 reset clk_src", clk_src, 2'b00);

    wr(8'h00);
    chk("R1 bit2 ignores write", reg_rdata, 8'h04);
    wr(8'hFB);
    chk("R1 full write", reg_rdata, 8'hFF);

    for (int i = 0; i < 9; i++) begin
      v = VEC[i];
      n = int'(v[16:0]);
      wr(v[31:24]);
      subtmr_en = v[23];
      pulse_sleep();
      chk("R2 R3 sleep target", mode, {29'd0, v[22:20]});
      chk("R8 no run while asleep", cpu_run, 1'b0);
      pulse_wake();
      if (n == 0) begin
        chk("R4 immediate resume", mode, {29'd0, v[19:17]});
      end else begin
        chk("R5 stabilising mode", mode, 3'd6);
        repeat (n - 1) @(negedge clk);
        chk("R5 still held at N-1", cpu_run, 1'b0);
        @(negedge clk);
        chk("R5 run at N", cpu_run, 1'b1);
        chk("R5 resumed mode", mode, {29'd0, v[19:17]});
      end
      subtmr_en = 1'b0;
    end

    // R8: wake ignored while running, sleep ignored while asleep
    wr(8'h00);
    pulse_wake();
    chk("R8 wake ignored in run", mode, 3'd0);
    pulse_sleep();
    pulse_sleep();
    chk("R8 sleep ignored in sleep", mode, 3'd2);
    pulse_wake();
    chk("R4 back to active", mode, 3'd0);

    // R7: write during wait leaves wait intact (code 7 -> 16)
    wr(8'hF0);
    pulse_sleep();
    chk("R3 standby", mode, 3'd4);
    pulse_wake();
    wr(8'hD0);
    chk("R7 register updated", reg_rdata, 8'hD4);
    repeat (14) @(negedge clk);
    chk("R7 wait unchanged at 15", cpu_run, 1'b0);
    @(negedge clk);
    chk("R7 run at 16", cpu_run, 1'b1);

    // R9
    wr(8'h08);
    chk("R9 subclock", clk_src, 2'b10);
    med_req = 1'b1;
    wr(8'h00);
    chk("R9 medium", clk_src, 2'b01);
    med_req = 1'b0;
    @(negedge clk);
    chk("R9 system", clk_src, 2'b00);

    // R10
    for (int m = 0; m < 4; m++) begin
      wr(8'(m));
      while (!med_tick) @(negedge clk);
      per = 0;
      do begin @(negedge clk); per++; end while (!med_tick);
      chk("R10 tick period", per, 32'd16 << m);
    end

    // R6: alternate table, code 2 -> 32768
    a_we = 1'b1; a_wd = 8'hA0;
    @(negedge clk);
    a_we = 1'b0; a_slp = 1'b1;
    @(negedge clk);
    a_slp = 1'b0;
    chk("R6 alt standby", a_mode, 3'd4);
    a_wk = 1'b1;
    @(negedge clk);
    a_wk = 1'b0;
    repeat (32767) @(negedge clk);
    chk("R6 alt held at N-1", a_run, 1'b0);
    @(negedge clk);
    chk("R6 alt run at N", a_run, 1'b1);

    finish_run();
  end
endmodule